// File: doc/BRIEF.md
# Byte Arithmetic/Logic Unit with Status Flags

This block is the arithmetic core of an 8-bit accumulator datapath. On a start pulse it takes the accumulator byte, a second operand byte, an operation code and the current status flags. The flags are carry, auxiliary (half) carry and signed overflow. It returns the new accumulator byte, a second result byte and the updated flags. Parity of the result accumulator is produced on every operation. It is always even: the ones in the result plus the parity bit make an even count.

The supported operations are add, add-with-carry, subtract-with-borrow, increment, decrement, AND, OR, XOR and unsigned multiply. Each operation has its own rule for which flags it writes. An operation that does not write carry, auxiliary carry or overflow passes the incoming value of that flag to the output. Multiply runs as an iterative shift-and-add, one operand bit per clock. Every other operation finishes in a single clock.

The control is a three-state machine:
- `ST_IDLE` waits for `start_i`. It goes to `ST_DONE` for a single-cycle operation, or to `ST_MUL` for multiply.
- `ST_MUL` stays in place for WIDTH step cycles, then goes to `ST_DONE` on the last step.
- `ST_DONE` raises `done_o` for one cycle and always goes back to `ST_IDLE`.

Results stay on the outputs until the next accepted operation.

Top module: `byte_alu_flags`

## Requirements
- R1: After reset, `res_o`, `hi_o`, `cy_o`, `ac_o`, `ov_o`, `par_o`, `busy_o` and `done_o` are all 0.
- R2: Add (op 0) and add-with-carry (op 1) give res = acc + opnd (+ `cy_i` for op 1) modulo 256. C is the carry out of bit 7. AC is the carry out of bit 3. OV is set when two operands of the same sign give a result of the other sign.
- R3: Subtract-with-borrow (op 2) gives res = acc − opnd − `cy_i` modulo 256. C is the borrow out of bit 7. AC is the borrow out of bit 3. OV is set when operands of different sign give a result whose sign differs from acc.
- R4: Increment (op 3) and decrement (op 4) wrap FFh→00h and 00h→FFh. C, AC and OV equal the incoming `cy_i`, `ac_i` and `ov_i`.
- R5: AND (op 5), OR (op 6) and XOR (op 7) combine acc with opnd bitwise. C, AC and OV equal the incoming flags.
- R6: Multiply (op 8) puts the low product byte on `res_o` and the high product byte on `hi_o`. It clears C, sets OV exactly when the high byte is non-zero, and passes AC through from `ac_i`.
- R7: `par_o` is the XOR of all bits of `res_o`.
- R8: For every operation except multiply, `hi_o` equals the second operand.
- R9: `done_o` is high for exactly one cycle. It is seen 1 clock edge after a single-cycle operation is accepted, and WIDTH+1 edges after a multiply is accepted. `busy_o` is high from acceptance until `done_o` has dropped.
- R10: `start_i` is ignored while `busy_o` is high, so the running operation's result is unaffected.
- R11: Op codes 9 to 15 return res = acc and `hi_o` = opnd, with C, AC and OV equal to the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start an operation (taken only when idle) |
| op_i | input | 4 | Operation code |
| acc_i | input | WIDTH | Accumulator operand |
| opnd_i | input | WIDTH | Second operand |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| res_o | output | WIDTH | Result accumulator byte |
| hi_o | output | WIDTH | Second result byte (high product for multiply) |
| cy_o | output | 1 | Updated carry |
| ac_o | output | 1 | Updated auxiliary carry |
| ov_o | output | 1 | Updated overflow |
| par_o | output | 1 | Even parity of the result accumulator |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a second start request that arrives while a multiply is still stepping. A normal caller waits for `done_o`, so this never happens by accident. The bench launches a multiply and then holds `start_i` high with a conflicting add while the state machine is in its step state. It then checks that the completed product, the flags and the latency all belong to the multiply. A two-byte addition is also chained, with the carry output fed back as the next carry input, so that the carry rule of add-with-carry is exercised across bytes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_MUL  = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DONE = 2'd2
    } alu_state_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_flags_t       flags_i,
    output logic [WIDTH-1:0] res_o,
    output logic [WIDTH-1:0] hi_o,
    output alu_flags_t       flags_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0]   cin_ext;
    logic [WIDTH:0]   add_full;
    logic [WIDTH:0]   sub_full;
    logic [WIDTH-1:0] add_res;
    logic [WIDTH-1:0] sub_res;
    logic             use_cin;

    always_comb begin
        use_cin  = (op_i == OP_ADDC) || (op_i == OP_SUBB);
        cin_ext  = {{WIDTH{1'b0}}, (use_cin & flags_i.cy)};
        add_full = {1'b0, a_i} + {1'b0, b_i} + cin_ext;
        sub_full = {1'b0, a_i} - {1'b0, b_i} - cin_ext;
        add_res  = add_full[WIDTH-1:0];
        sub_res  = sub_full[WIDTH-1:0];
    end

    always_comb begin
        res_o   = a_i;
        hi_o    = b_i;
        flags_o = flags_i;
        unique case (op_i)
            OP_ADD, OP_ADDC: begin
                res_o      = add_res;
                flags_o.cy = add_full[WIDTH];
                flags_o.ac = a_i[HALF] ^ b_i[HALF] ^ add_res[HALF];
                flags_o.ov = (a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                             (add_res[WIDTH-1] != a_i[WIDTH-1]);
            end
            OP_SUBB: begin
                res_o      = sub_res;
                flags_o.cy = sub_full[WIDTH];
                flags_o.ac = a_i[HALF] ^ b_i[HALF] ^ sub_res[HALF];
                flags_o.ov = (a_i[WIDTH-1] != b_i[WIDTH-1]) &&
                             (sub_res[WIDTH-1] != a_i[WIDTH-1]);
            end
            OP_INC:  res_o = a_i + {{(WIDTH-1){1'b0}}, 1'b1};
            OP_DEC:  res_o = a_i - {{(WIDTH-1){1'b0}}, 1'b1};
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: begin
                res_o   = a_i;
                flags_o = flags_i;
            end
        endcase
    end

endmodule

// File: rtl/alu8_mult.sv
module alu8_mult #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic [WIDTH-1:0] hi_next_o,
    output logic [WIDTH-1:0] lo_next_o
);
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [WIDTH-1:0] addend;
    logic [WIDTH:0]   partial;

    always_comb begin
        addend    = lo_q[0] ? mcand_q : '0;
        partial   = {1'b0, hi_q} + {1'b0, addend};
        hi_next_o = partial[WIDTH:1];
        lo_next_o = {partial[0], lo_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (load_i) begin
            mcand_q <= mcand_i;
            hi_q    <= '0;
            lo_q    <= mplier_i;
        end else if (step_i) begin
            hi_q    <= hi_next_o;
            lo_q    <= lo_next_o;
        end
    end

    // R6: a fresh multiply starts from a cleared high half and the new multiplier
    p_mul_load_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (hi_q == '0) && (lo_q == $past(mplier_i)));

    // R6: the multiplicand is held for the whole stepping sequence
    p_mcand_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> $stable(mcand_q));

endmodule

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       is_mul_i,
    output alu_state_e state_o,
    output logic       alu_load_o,
    output logic       mul_load_o,
    output logic       mul_step_o,
    output logic       mul_last_o
);
    localparam int CNTW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(WIDTH - 1);

    alu_state_e      state_q;
    alu_state_e      state_d;
    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        alu_load_o = 1'b0;
        mul_load_o = 1'b0;
        mul_step_o = 1'b0;
        mul_last_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (is_mul_i) begin
                        mul_load_o = 1'b1;
                        state_d    = ST_MUL;
                    end else begin
                        alu_load_o = 1'b1;
                        state_d    = ST_DONE;
                    end
                end
            end
            ST_MUL: begin
                mul_step_o = 1'b1;
                if (cnt_q == LAST) begin
                    mul_last_o = 1'b1;
                    state_d    = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (mul_load_o) cnt_q <= '0;
        else if (mul_step_o) cnt_q <= cnt_q + {{(CNTW-1){1'b0}}, 1'b1};
    end

    assign state_o = state_q;

    // R9: the completion state lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R9: multiply keeps stepping until its final bit
    p_mul_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL && cnt_q != LAST) |=> (state_q == ST_MUL));

    // R9: the final step always completes
    p_mul_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL && cnt_q == LAST) |=> (state_q == ST_DONE));

endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             cy_i,
    input  logic             ac_i,
    input  logic             ov_i,
    output logic [WIDTH-1:0] res_o,
    output logic [WIDTH-1:0] hi_o,
    output logic             cy_o,
    output logic             ac_o,
    output logic             ov_o,
    output logic             par_o,
    output logic             busy_o,
    output logic             done_o
);
    alu_state_e       state;
    logic             alu_load;
    logic             mul_load;
    logic             mul_step;
    logic             mul_last;
    logic             is_mul;
    alu_flags_t       in_flags;
    alu_flags_t       ar_flags;
    logic [WIDTH-1:0] ar_res;
    logic [WIDTH-1:0] ar_hi;
    logic [WIDTH-1:0] mul_hi;
    logic [WIDTH-1:0] mul_lo;

    logic [WIDTH-1:0] res_q;
    logic [WIDTH-1:0] hi_q;
    alu_flags_t       flags_q;
    alu_flags_t       keep_q;
    logic [3:0]       op_q;

    assign is_mul   = (op_i == OP_MUL);
    assign in_flags = '{cy: cy_i, ac: ac_i, ov: ov_i};

    alu8_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .is_mul_i   (is_mul),
        .state_o    (state),
        .alu_load_o (alu_load),
        .mul_load_o (mul_load),
        .mul_step_o (mul_step),
        .mul_last_o (mul_last)
    );

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .op_i    (op_i),
        .a_i     (acc_i),
        .b_i     (opnd_i),
        .flags_i (in_flags),
        .res_o   (ar_res),
        .hi_o    (ar_hi),
        .flags_o (ar_flags)
    );

    alu8_mult #(.WIDTH(WIDTH)) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (mul_load),
        .step_i    (mul_step),
        .mcand_i   (acc_i),
        .mplier_i  (opnd_i),
        .hi_next_o (mul_hi),
        .lo_next_o (mul_lo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            hi_q    <= '0;
            flags_q <= '0;
            keep_q  <= '0;
            op_q    <= '0;
        end else begin
            if (alu_load || mul_load) begin
                op_q   <= op_i;
                keep_q <= in_flags;
            end
            if (alu_load) begin
                res_q   <= ar_res;
                hi_q    <= ar_hi;
                flags_q <= ar_flags;
            end else if (mul_last) begin
                res_q      <= mul_lo;
                hi_q       <= mul_hi;
                flags_q.cy <= 1'b0;
                flags_q.ac <= keep_q.ac;
                flags_q.ov <= |mul_hi;
            end
        end
    end

    always_comb begin
        res_o  = res_q;
        hi_o   = hi_q;
        cy_o   = flags_q.cy;
        ac_o   = flags_q.ac;
        ov_o   = flags_q.ov;
        par_o  = ^res_q;
        busy_o = (state != ST_IDLE);
        done_o = (state == ST_DONE);
    end

    // R6: multiply flag rules at completion
    p_mul_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_MUL) |->
            (!cy_o && (ov_o == (hi_o != '0)) && (ac_o == keep_q.ac)));

    // R4: increment and decrement pass the flags through
    p_incdec_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_q == OP_INC || op_q == OP_DEC)) |->
            ({cy_o, ac_o, ov_o} == keep_q));

    // R5: logic operations pass the flags through
    p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR)) |->
            ({cy_o, ac_o, ov_o} == keep_q));

    // R11: reserved codes pass the flags through
    p_reserved_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q > 4'd8) |-> ({cy_o, ac_o, ov_o} == keep_q));

    // R10: a running operation's code cannot be replaced
    p_op_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(op_q));

endmodule

// File: tb/tb_byte_alu_flags.sv
module tb_byte_alu_flags;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       cy_i = 1'b0;
    logic       ac_i = 1'b0;
    logic       ov_i = 1'b0;
    logic [7:0] res_o;
    logic [7:0] hi_o;
    logic       cy_o, ac_o, ov_o, par_o, busy_o, done_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    byte_alu_flags #(.WIDTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
        .res_o(res_o), .hi_o(hi_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
        .par_o(par_o), .busy_o(busy_o), .done_o(done_o)
    );

    // {op, acc, opnd, cy/ac/ov in, expected res, expected hi}
    localparam logic [38:0] VEC [0:15] = '{
        {4'd0,  8'h3A, 8'h27, 3'b000, 8'h61, 8'h27},
        {4'd0,  8'hFF, 8'h01, 3'b000, 8'h00, 8'h01},
        {4'd0,  8'h7F, 8'h01, 3'b000, 8'h80, 8'h01},
        {4'd1,  8'h10, 8'h20, 3'b100, 8'h31, 8'h20},
        {4'd2,  8'h50, 8'h20, 3'b100, 8'h2F, 8'h20},
        {4'd2,  8'h00, 8'h01, 3'b000, 8'hFF, 8'h01},
        {4'd2,  8'h80, 8'h01, 3'b000, 8'h7F, 8'h01},
        {4'd3,  8'hFF, 8'h55, 3'b101, 8'h00, 8'h55},
        {4'd4,  8'h00, 8'hAA, 3'b010, 8'hFF, 8'hAA},
        {4'd5,  8'hF0, 8'h3C, 3'b111, 8'h30, 8'h3C},
        {4'd6,  8'hA0, 8'h05, 3'b000, 8'hA5, 8'h05},
        {4'd7,  8'hFF, 8'h0F, 3'b101, 8'hF0, 8'h0F},
        {4'd8,  8'h0C, 8'h0A, 3'b111, 8'h78, 8'h00},
        {4'd8,  8'hFF, 8'hFF, 3'b010, 8'h01, 8'hFE},
        {4'd8,  8'h80, 8'h02, 3'b101, 8'h00, 8'h01},
        {4'd15, 8'h5A, 8'hC3, 3'b110, 8'h5A, 8'hC3}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string op_req(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:       return "R2";
            4'd2:             return "R3";
            4'd3, 4'd4:       return "R4";
            4'd5, 4'd6, 4'd7: return "R5";
            4'd8:             return "R6";
            default:          return "R11";
        endcase
    endfunction

    // expected {cy, ac, ov} from the flag rules of the requirements
    function automatic logic [2:0] exp_flags(input logic [3:0] op, input int a,
                                             input int b, input logic [2:0] fin,
                                             input int res, input int hi);
        int ci;
        logic c, h, v;
        ci = (op == 4'd1 || op == 4'd2) ? int'(fin[2]) : 0;
        case (op)
            4'd0, 4'd1: begin
                c = (a + b + ci) > 255;
                h = ((a % 16) + (b % 16) + ci) > 15;
                v = (((a ^ res) & (b ^ res) & 128) != 0);
                return {c, h, v};
            end
            4'd2: begin
                c = (a - b - ci) < 0;
                h = ((a % 16) - (b % 16) - ci) < 0;
                v = (((a ^ b) & (a ^ res) & 128) != 0);
                return {c, h, v};
            end
            4'd8:    return {1'b0, fin[1], (hi != 0)};
            default: return fin;
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [2:0] fin,
                          output int lat);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; {cy_i, ac_i, ov_i} = fin;
        start_i = 1'b1;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start_i = 1'b0;
        end while (!done_o && lat < 40);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int lat;
        logic [7:0] low_byte;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 res", res_o, 0);
        check("R1 hi", hi_o, 0);
        check("R1 flags", {cy_o, ac_o, ov_o, par_o}, 0);
        check("R1 busy/done", {busy_o, done_o}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++) begin
            logic [3:0] op;
            logic [7:0] a, b, er, eh;
            logic [2:0] fin;
            {op, a, b, fin, er, eh} = VEC[i];
            run_op(op, a, b, fin, lat);
            check({op_req(op), " res"}, res_o, er);
            check((op == 4'd8) ? "R6 hi" : "R8 hi", hi_o, eh);
            check({op_req(op), " flags"}, {cy_o, ac_o, ov_o},
                  exp_flags(op, a, b, fin, er, eh));
            check("R7 parity", par_o, ^er);
            check("R9 latency", lat, (op == 4'd8) ? 9 : 1);
            @(negedge clk);
            check("R9 done pulse", {done_o, busy_o}, 0);
            check("R9 result held", res_o, er);
        end

        // R2: two-byte add 01FFh + 0001h with carry chained
        run_op(4'd0, 8'hFF, 8'h01, 3'b000, lat);
        low_byte = res_o;
        run_op(4'd1, 8'h01, 8'h00, {cy_o, 2'b00}, lat);
        check("R2 chained add", {res_o, low_byte}, 16'h0200);

        // R9/R10: busy during multiply, start with an add ignored
        @(negedge clk);
        op_i = 4'd8; acc_i = 8'h03; opnd_i = 8'h05; {cy_i, ac_i, ov_i} = 3'b000;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 busy in multiply", busy_o, 1);
        op_i = 4'd0; acc_i = 8'h01; opnd_i = 8'h01;
        lat = 1;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!done_o && lat < 40);
        start_i = 1'b0;
        check("R10 product kept", {hi_o, res_o}, 16'h000F);
        check("R10 latency kept", lat, 9);
        check("R10 multiply flags", {cy_o, ov_o}, 0);
        repeat (3) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule